// File: doc/BRIEF.md
# Quad DAC Double-Buffered Bus Interface

This block is the digital register front end of a four-channel, 14-bit digital-to-analog converter that is loaded over a narrow parallel bus. A host selects the device with an active-low select, presents an address and a data byte, and pulses an active-low write strobe. The write lands in one of four input registers, or in all four at once. Because the bus carries one byte, an upper-byte select routes the low six data bits into the top of the 14-bit word, so two writes build a full code.

Each channel has a second stage, the DAC latch, which drives the converter. An active-low load input controls the path from the input registers to the latches. A falling load edge copies all four input registers at once. While load is held low, each write also passes straight through to the addressed latch. An asynchronous active-low clear puts every channel into a clamp state, in which the analog output follows a sense-ground potential. That clamp remains after clear is released and only ends when load is next low. The block produces the per-channel and per-pair clamp flags; the analog switching is not part of it.

All bus and control inputs pass through a two-flop synchronizer into the system clock domain. Edges are then detected one stage later. The only exception is clear, which sets the clamp flags without waiting for a clock.

Top module: `quad_dac_bus_if`

## Requirements
- R1: On a write with address bit 2 at 0, address bits 1:0 select channel 0 to 3, and only that channel's input register changes.
- R2: On a write with address bit 2 at 1, all four input registers take the same data, whatever bits 1:0 hold.
- R3: A write is committed on the rising edge of the write strobe, and only if select is low. A write strobe pulse while select is high changes no register.
- R4: With the upper-byte select low, data bits 5:0 go into bits 13:8 and bits 7:0 are kept. With it high, data bits 7:0 go into bits 7:0 and bits 13:8 are kept.
- R5: While load is high, writes leave every DAC latch output unchanged.
- R6: A falling edge on load, with clear high, copies all four input registers into their DAC latches on the same clock.
- R7: While load is low and clear is high, a write also updates the addressed DAC latch or latches. A write, a load edge or a clamp release is visible at the outputs no later than 4 clock cycles after the input change.
- R8: Clear low sets all four clamp flags at once, without waiting for a clock edge.
- R9: After clear returns high, the clamp flags stay set while load stays high. They drop when load is low and clear is high.
- R10: While clear is low, load is ignored: it neither transfers registers nor releases the clamp, and writes do not reach the DAC latches.
- R11: Group clamp flag 0 reflects channels 0 and 1, and group clamp flag 1 reflects channels 2 and 3.
- R12: After reset, all input registers and DAC latches are zero and all clamp flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Bus select, active low |
| wr_ni | input | 1 | Write strobe, active low, committed on its rising edge |
| addr_i | input | 3 | Bits 1:0 channel, bit 2 broadcast |
| data_i | input | 8 | Bus data byte |
| hi_sel_ni | input | 1 | Low: byte goes to upper six bits |
| load_ni | input | 1 | Load control, active low |
| clear_ni | input | 1 | Asynchronous clear to clamp, active low |
| dac_o | output | 4x14 | DAC latch values, channel n at [n] |
| clamp_o | output | 4 | Per-channel clamp flags |
| grp_clamp_o | output | 2 | Clamp flags for channel pairs 0/1 and 2/3 |

## Verification
Assertions check on every cycle that an unaddressed input register stays the same and that clear low implies all clamps set. They also check that a clamp holds while load is high, that a load edge leaves the latches equal to the input registers, and that the latches freeze while clear is low. The bench's scenarios show what a single cycle cannot: byte assembly from two writes, broadcast writes, the order of clear, release and load over many cycles, and the clamp rising with no clock edge.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;
  localparam int unsigned NCH  = 4;
  localparam int unsigned DW   = 14;
  localparam int unsigned BW   = 8;
  localparam int unsigned AW   = 3;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST;
      s2_q <= RST;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/input_bank.sv
module input_bank #(
  parameter int unsigned NCH = quad_dac_pkg::NCH,
  parameter int unsigned DW  = quad_dac_pkg::DW,
  parameter int unsigned BW  = quad_dac_pkg::BW,
  parameter int unsigned AW  = quad_dac_pkg::AW
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_pulse_i,
  input  logic [AW-1:0]           addr_i,
  input  logic                    hi_sel_ni,
  input  logic [BW-1:0]           data_i,
  output logic [NCH-1:0][DW-1:0]  in_q_o,
  output logic [NCH-1:0][DW-1:0]  in_nx_o,
  output logic [NCH-1:0]          hit_o
);
  localparam int unsigned SEL_W = $clog2(NCH);
  localparam int unsigned HI_W  = DW - BW;

  logic [NCH-1:0][DW-1:0] in_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign hit_o[g] = wr_pulse_i &
                      (addr_i[AW-1] | (addr_i[SEL_W-1:0] == SEL_W'(g)));

    always_comb begin
      in_nx_o[g] = in_q[g];
      if (hit_o[g]) begin
        if (!hi_sel_ni) in_nx_o[g] = {data_i[HI_W-1:0], in_q[g][BW-1:0]};
        else            in_nx_o[g] = {in_q[g][DW-1:BW], data_i};
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) in_q[g] <= '0;
      else         in_q[g] <= in_nx_o[g];
    end

    // unaddressed register never moves
    assert_unaddressed_hold_R1: assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      !hit_o[g] |=> $stable(in_q[g]));
  end

  assign in_q_o = in_q;
endmodule

// File: rtl/latch_bank.sv
module latch_bank #(
  parameter int unsigned NCH = quad_dac_pkg::NCH,
  parameter int unsigned DW  = quad_dac_pkg::DW
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_ni,
  input  logic                    clr_ok_i,
  input  logic                    ld_low_i,
  input  logic                    ld_fall_i,
  input  logic [NCH-1:0]          hit_i,
  input  logic [NCH-1:0][DW-1:0]  in_nx_i,
  output logic [NCH-1:0][DW-1:0]  lat_o,
  output logic [NCH-1:0]          clamp_o
);
  logic xfer_all;
  logic release_ok;

  assign xfer_all   = ld_fall_i & clr_ok_i;
  assign release_ok = ld_low_i & clr_ok_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic pass_thru;
    assign pass_thru = hit_i[g] & ld_low_i & clr_ok_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   lat_o[g] <= '0;
      else if (xfer_all | pass_thru) lat_o[g] <= in_nx_i[g];
    end

    // clear sets the clamp without a clock
    always_ff @(posedge clk_i or negedge rst_ni or negedge clear_ni) begin
      if (!rst_ni)         clamp_o[g] <= 1'b1;
      else if (!clear_ni)  clamp_o[g] <= 1'b1;
      else if (release_ok) clamp_o[g] <= 1'b0;
    end

    assert_clamp_hold_R9: assert property (
      @(posedge clk_i) disable iff (!rst_ni)
      (clamp_o[g] && !ld_low_i) |=> clamp_o[g]);
  end

  assert_clear_sets_clamp_R8: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    !clear_ni |-> (&clamp_o));

  assert_clear_freezes_latch_R10: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    !clr_ok_i |=> $stable(lat_o));
endmodule

// File: rtl/quad_dac_bus_if.sv
module quad_dac_bus_if #(
  parameter int unsigned NCH = quad_dac_pkg::NCH,
  parameter int unsigned DW  = quad_dac_pkg::DW,
  parameter int unsigned BW  = quad_dac_pkg::BW,
  parameter int unsigned AW  = quad_dac_pkg::AW
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_ni,
  input  logic                   wr_ni,
  input  logic [AW-1:0]          addr_i,
  input  logic [BW-1:0]          data_i,
  input  logic                   hi_sel_ni,
  input  logic                   load_ni,
  input  logic                   clear_ni,
  output logic [NCH-1:0][DW-1:0] dac_o,
  output logic [NCH-1:0]         clamp_o,
  output logic [1:0]             grp_clamp_o
);
  localparam int unsigned CW   = 5;
  localparam int unsigned BUSW = AW + BW;
  localparam int unsigned HALF = NCH / 2;

  logic [CW-1:0]   ctl_s;
  logic [BUSW-1:0] bus_s;
  logic cs_s, wr_s, ld_s, clr_s, hi_s;
  logic [AW-1:0] addr_s;
  logic [BW-1:0] data_s;

  bus_sync #(.W(CW), .RST({CW{1'b1}})) u_ctl_sync (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .d_i   ({cs_ni, wr_ni, load_ni, clear_ni, hi_sel_ni}),
    .q_o   (ctl_s));

  bus_sync #(.W(BUSW), .RST('0)) u_bus_sync (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .d_i   ({addr_i, data_i}),
    .q_o   (bus_s));

  assign {cs_s, wr_s, ld_s, clr_s, hi_s} = ctl_s;
  assign {addr_s, data_s} = bus_s;

  // one more stage for edge detection; bus fields taken while strobe low
  logic cs_d, wr_d, ld_d, hi_d;
  logic [AW-1:0] addr_d;
  logic [BW-1:0] data_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d <= 1'b1; wr_d <= 1'b1; ld_d <= 1'b1; hi_d <= 1'b1;
      addr_d <= '0; data_d <= '0;
    end else begin
      cs_d <= cs_s; wr_d <= wr_s; ld_d <= ld_s; hi_d <= hi_s;
      addr_d <= addr_s; data_d <= data_s;
    end
  end

  logic wr_pulse, ld_fall;
  assign wr_pulse = wr_s & ~wr_d & ~cs_d;
  assign ld_fall  = ~ld_s & ld_d;

  logic [NCH-1:0][DW-1:0] in_q, in_nx;
  logic [NCH-1:0]         hit;

  input_bank #(.NCH(NCH), .DW(DW), .BW(BW), .AW(AW)) u_in (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_pulse_i(wr_pulse),
    .addr_i    (addr_d),
    .hi_sel_ni (hi_d),
    .data_i    (data_d),
    .in_q_o    (in_q),
    .in_nx_o   (in_nx),
    .hit_o     (hit));

  latch_bank #(.NCH(NCH), .DW(DW)) u_lat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_ni (clear_ni),
    .clr_ok_i (clr_s),
    .ld_low_i (~ld_s),
    .ld_fall_i(ld_fall),
    .hit_i    (hit),
    .in_nx_i  (in_nx),
    .lat_o    (dac_o),
    .clamp_o  (clamp_o));

  assign grp_clamp_o[0] = |clamp_o[HALF-1:0];
  assign grp_clamp_o[1] = |clamp_o[NCH-1:HALF];

  assert_load_edge_copies_R6: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (ld_fall && clr_s) |=> (dac_o == in_q));

  assert_load_high_freezes_R5: assert property (
    @(posedge clk_i) disable iff (!rst_ni)
    (ld_s && !ld_fall) |=> $stable(dac_o));
endmodule

// File: tb/quad_dac_bus_if_bench.sv
module quad_dac_bus_if_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NCH = 4;
  localparam int unsigned DW  = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, hi_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] data = '0;
  logic [NCH-1:0][DW-1:0] dac;
  logic [NCH-1:0] clamp;
  logic [1:0] grp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [DW-1:0] in_m [NCH];
  logic [DW-1:0] lat_m [NCH];
  logic clamp_m, ld_m, clr_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_dac_bus_if u_quad_dac_bus_if (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n),
    .addr_i(addr), .data_i(data), .hi_sel_ni(hi_n), .load_ni(ld_n),
    .clear_ni(clr_n), .dac_o(dac), .clamp_o(clamp), .grp_clamp_o(grp));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < NCH; i++) chk(req, 32'(dac[i]), 32'(lat_m[i]));
    chk(req, 32'(clamp), clamp_m ? 32'hF : 32'h0);
    chk({req, "/R11"}, 32'(grp), clamp_m ? 32'h3 : 32'h0);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                          input logic hsel_n, input logic [7:0] d);
    return hsel_n ? {old[13:8], d} : {d[5:0], old[7:0]};
  endfunction

  task automatic do_write(input logic [2:0] a, input logic hsel_n,
                          input logic [7:0] d, input logic sel);
    addr = a; data = d; hi_n = hsel_n; cs_n = ~sel;
    wait_clk(4); wr_n = 1'b0;
    wait_clk(4); wr_n = 1'b1;
    wait_clk(4); cs_n = 1'b1;
    wait_clk(4);
    if (sel) begin
      for (int i = 0; i < NCH; i++) begin
        if (a[2] || a[1:0] == 2'(i)) begin
          in_m[i] = merge(in_m[i], hsel_n, d);
          if (!ld_m && clr_m) lat_m[i] = in_m[i];
        end
      end
    end
  endtask

  task automatic set_load(input logic v);
    if (ld_m && !v && clr_m)
      for (int i = 0; i < NCH; i++) lat_m[i] = in_m[i];
    ld_m = v; ld_n = v;
    if (!v && clr_m) clamp_m = 1'b0;
    wait_clk(6);
  endtask

  task automatic set_clear(input logic v);
    clr_m = v; clr_n = v;
    if (!v) clamp_m = 1'b1;
    else if (!ld_m) clamp_m = 1'b0;
    wait_clk(6);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin in_m[i] = '0; lat_m[i] = '0; end
    clamp_m = 1'b1; ld_m = 1'b1; clr_m = 1'b1;
    void'($urandom(32'd1234));
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    check_all("R12");

    // R5: write with load high, outputs frozen
    do_write(3'b001, 1'b1, 8'hA5, 1'b1);
    check_all("R5");
    do_write(3'b001, 1'b0, 8'h2B, 1'b1);
    check_all("R4");
    // R6: load edge copies all, releases clamp (R9)
    set_load(1'b0);
    check_all("R6");
    chk("R4", 32'(dac[1]), 32'h2BA5);
    set_load(1'b1);
    // R3: strobe without select
    do_write(3'b000, 1'b1, 8'hFF, 1'b0);
    set_load(1'b0);
    check_all("R3");
    chk("R3", 32'(dac[0]), 32'h0);
    // R7: transparent write while load low
    do_write(3'b011, 1'b1, 8'h5C, 1'b1);
    check_all("R7");
    chk("R1", 32'(dac[2]), 32'h0);
    // R2: broadcast, bits 1:0 ignored
    do_write(3'b110, 1'b0, 8'h3F, 1'b1);
    check_all("R2");
    set_load(1'b1);
    // R8: clamp rises with no clock edge
    @(negedge clk); #1;
    clr_n = 1'b0; clr_m = 1'b0; clamp_m = 1'b1;
    #1;
    chk("R8", 32'(clamp), 32'hF);
    wait_clk(6);
    // R10: load toggled and writes during clear
    do_write(3'b010, 1'b1, 8'h77, 1'b1);
    set_load(1'b0);
    check_all("R10");
    do_write(3'b010, 1'b0, 8'h11, 1'b1);
    check_all("R10");
    set_load(1'b1);
    // R9: clear released, clamp held until load low
    set_clear(1'b1);
    check_all("R9");
    wait_clk(20);
    check_all("R9");
    set_load(1'b0);
    check_all("R9");
    set_load(1'b1);

    // random phase
    for (int n = 0; n < 300; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 6)
        do_write(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                 8'($urandom_range(0, 255)), $urandom_range(0, 9) != 0);
      else if (op < 9)
        set_load(~ld_m);
      else
        set_clear(~clr_m);
      check_all("R1");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule